// File: doc/BRIEF.md
# Reference Pulse Phase Calibration Sequencer

This block searches for a fine-delay setting at which a periodic reference pulse is captured with margin by a local sampling flop. It drives a fine-delay code and a one-cycle coarse slip request toward an external clock distributor, and it reads back the one-bit captured value of the pulse. It waits a programmable number of cycles after every change, because the delay path needs time to settle.

A start pulse runs the search. First the block slips the pulse until a stable reading is low, and then it slips until a stable reading is high. A reading counts as stable only when the captured values at the nominal offset and at the offset minus five agree. The block then lowers the fine delay one code at a time from the nominal offset. The first code that captures low, plus a fixed guard of 17, becomes the reported offset. Each phase has its own slip budget, and each failure has its own error code. Done, error and result hold their values until the next start.

Top module: `pulse_phase_cal`

## Requirements
- R1: After reset, busy_o, done_o, slip_o, err_o and result_o are all zero, and fine_dly_o equals the nominal offset 136.
- R2: A start_i pulse while idle clears done_o, err_o and result_o and raises busy_o on the next cycle. A start_i pulse while busy has no effect on the outcome.
- R3: A reading is classed from two captures, one at fine code 136 and one at fine code 131. Two low captures mean low and two high captures mean high. Any mix means unstable, and unstable never satisfies a phase.
- R4: Phase one slips while the class is not low. If the class is still not low after 1024 slips, the block stops with err_o = 1 and issues no further slip.
- R5: Phase two has a fresh budget and slips while the class is not high. If it is still not high after 1024 slips, the block stops with err_o = 2.
- R6: The sweep tries fine codes 136, 135, ... down to 1. At the first code f that captures low, the block ends with err_o = 0 and result_o = f + 17.
- R7: If codes 136 down to 1 all capture high, the block ends with err_o = 3. Code 0 is never applied.
- R8: Between two successive events (a slip_o pulse or a change of fine_dly_o), at least settle_cyc_i + 1 cycles pass.
- R9: At the end of a run, done_o rises and busy_o falls. done_o, err_o and result_o then hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; ignored while busy |
| settle_cyc_i | input | 8 | Extra wait cycles after every change, before the capture is used |
| sample_i | input | 1 | Captured value of the reference pulse |
| fine_dly_o | output | 16 | Fine-delay code to the distributor |
| slip_o | output | 1 | One-cycle coarse slip request |
| busy_o | output | 1 | Search running |
| done_o | output | 1 | Search finished, held |
| err_o | output | 2 | 0 ok, 1 no low found, 2 no high found, 3 no low code in sweep |
| result_o | output | 16 | Chosen offset (first low code + 17), valid when done_o and err_o = 0 |

## Verification
The assertions check, on every cycle, properties that do not depend on the pulse:
- slip pulses last a single cycle;
- the fine code stays between 1 and 136 while the block is busy;
- the slip budget never passes its limit;
- the settle counter only counts down;
- finished outputs hold steady and are never set while the block is busy;
- a start pulse taken while idle clears done.

Only the bench scenarios can show that the search lands on the right code. The bench uses a modelled pulse that responds to slips and fine codes, and it covers:
- every starting slip phase and a range of fine skews;
- a budget of exactly 1024 slips against one slip too many in each phase;
- a mixed, unstable reading;
- the sweep limits at code 1 and code 0.

// File: rtl/pcal_pkg.sv
package pcal_pkg;
  typedef enum logic [1:0] {CLS_LOW, CLS_HIGH, CLS_UNST} cls_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_HI, ST_WAIT_LO, ST_SLIP, ST_SLIP_WAIT, ST_SWEEP
  } state_e;
  localparam logic [1:0] ERR_NONE    = 2'd0;
  localparam logic [1:0] ERR_NO_LOW  = 2'd1;
  localparam logic [1:0] ERR_NO_HIGH = 2'd2;
  localparam logic [1:0] ERR_NO_EDGE = 2'd3;
endpackage

// File: rtl/pcal_settle_timer.sv
module pcal_settle_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  AST_SETTLE_COUNTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8
endmodule

// File: rtl/pcal_slip_budget.sv
module pcal_slip_budget #(
  parameter int unsigned SLIP_MAX = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic full_o
);
  localparam int unsigned CW = $clog2(SLIP_MAX + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == CW'(SLIP_MAX));

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(SLIP_MAX)); // R4
endmodule

// File: rtl/pcal_classify.sv
module pcal_classify
  import pcal_pkg::*;
(
  input  logic first_i,
  input  logic second_i,
  output cls_e cls_o
);
  always_comb begin
    if (first_i != second_i) cls_o = CLS_UNST;
    else if (first_i)        cls_o = CLS_HIGH;
    else                     cls_o = CLS_LOW;
  end
endmodule

// File: rtl/pulse_phase_cal.sv
module pulse_phase_cal
  import pcal_pkg::*;
#(
  parameter int unsigned DLY_W     = 16,
  parameter int unsigned SETTLE_W  = 8,
  parameter int unsigned INIT_OFS  = 136,
  parameter int unsigned PROBE_GAP = 5,
  parameter int unsigned GUARD     = 17,
  parameter int unsigned SLIP_MAX  = 1024
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_cyc_i,
  input  logic                sample_i,
  output logic [DLY_W-1:0]    fine_dly_o,
  output logic                slip_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [1:0]          err_o,
  output logic [DLY_W-1:0]    result_o
);
  localparam logic [DLY_W-1:0] OFS_HI = DLY_W'(INIT_OFS);
  localparam logic [DLY_W-1:0] OFS_LO = DLY_W'(INIT_OFS - PROBE_GAP);
  localparam logic [DLY_W-1:0] OFS_GD = DLY_W'(GUARD);

  state_e           state_q, state_d;
  logic [DLY_W-1:0] fine_q, fine_d, res_q, res_d;
  logic             first_q, first_d, ph2_q, ph2_d, done_q, done_d;
  logic [1:0]       err_q, err_d;
  logic             tmr_load, tmr_exp, bud_clr, bud_inc, bud_full;
  cls_e             cls;
  cls_e             target;

  pcal_settle_timer #(.W(SETTLE_W)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(settle_cyc_i), .expired_o(tmr_exp)
  );

  pcal_slip_budget #(.SLIP_MAX(SLIP_MAX)) u_budget (
    .clk_i, .rst_ni, .clr_i(bud_clr), .inc_i(bud_inc), .full_o(bud_full)
  );

  pcal_classify u_cls (.first_i(first_q), .second_i(sample_i), .cls_o(cls));

  assign target = ph2_q ? CLS_HIGH : CLS_LOW;

  always_comb begin
    state_d  = state_q;
    fine_d   = fine_q;
    res_d    = res_q;
    first_d  = first_q;
    ph2_d    = ph2_q;
    done_d   = done_q;
    err_d    = err_q;
    tmr_load = 1'b0;
    bud_clr  = 1'b0;
    bud_inc  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        done_d   = 1'b0;
        err_d    = ERR_NONE;
        res_d    = '0;
        ph2_d    = 1'b0;
        bud_clr  = 1'b1;
        fine_d   = OFS_HI;
        tmr_load = 1'b1;
        state_d  = ST_WAIT_HI;
      end
      ST_WAIT_HI: if (tmr_exp) begin
        first_d  = sample_i;
        fine_d   = OFS_LO;
        tmr_load = 1'b1;
        state_d  = ST_WAIT_LO;
      end
      ST_WAIT_LO: if (tmr_exp) begin
        if (cls == target) begin
          fine_d   = OFS_HI;
          tmr_load = 1'b1;
          if (!ph2_q) begin
            ph2_d   = 1'b1;
            bud_clr = 1'b1;
            state_d = ST_WAIT_HI;
          end else begin
            state_d = ST_SWEEP;
          end
        end else if (bud_full) begin
          done_d  = 1'b1;
          err_d   = ph2_q ? ERR_NO_HIGH : ERR_NO_LOW;
          state_d = ST_IDLE;
        end else begin
          bud_inc = 1'b1;
          state_d = ST_SLIP;
        end
      end
      ST_SLIP: begin
        tmr_load = 1'b1;
        state_d  = ST_SLIP_WAIT;
      end
      ST_SLIP_WAIT: if (tmr_exp) begin
        fine_d   = OFS_HI;
        tmr_load = 1'b1;
        state_d  = ST_WAIT_HI;
      end
      ST_SWEEP: if (tmr_exp) begin
        if (!sample_i) begin
          res_d   = fine_q + OFS_GD;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (fine_q <= DLY_W'(1)) begin
          err_d   = ERR_NO_EDGE;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          fine_d   = fine_q - 1'b1;
          tmr_load = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fine_q  <= OFS_HI;
      res_q   <= '0;
      first_q <= 1'b0;
      ph2_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= ERR_NONE;
    end else begin
      state_q <= state_d;
      fine_q  <= fine_d;
      res_q   <= res_d;
      first_q <= first_d;
      ph2_q   <= ph2_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign fine_dly_o = fine_q;
  assign slip_o     = (state_q == ST_SLIP);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign result_o   = res_q;

  AST_SLIP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |=> !slip_o); // R4
  AST_FINE_CEILING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_dly_o <= OFS_HI); // R6
  AST_FINE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (fine_dly_o != '0)); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_HOLD_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(result_o) && $stable(err_o))); // R9
  AST_OK_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o == ERR_NONE) |-> (result_o > OFS_GD)); // R6
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && !done_o && err_o == ERR_NONE)); // R2
endmodule

// File: tb/tb_pulse_phase_cal.sv
module tb_pulse_phase_cal;
  localparam int INIT = 136;
  localparam int SLIP_LIM = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  settle = 8'd0;
  logic        sample;
  logic [15:0] fine;
  logic        slip, busy, done;
  logic [1:0]  err;
  logic [15:0] result;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, last_ev = -1000, viol = 0, slip_tot = 0, slip_base = 0;
  int m_mode = 0, m_a = 0, m_b = 0;
  logic [15:0] prev_fine = 16'd136;

  always #2.5 clk = ~clk;

  pulse_phase_cal dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .settle_cyc_i(settle),
    .sample_i(sample), .fine_dly_o(fine), .slip_o(slip), .busy_o(busy),
    .done_o(done), .err_o(err), .result_o(result)
  );

  // pulse model: s = slips since run start, f = fine code
  function automatic bit samp(int mode, int a, int b, int s, int f);
    case (mode)
      0:       return (((s + a) * 34 + f + b) % 272) < 136;
      1:       return !(s >= a && s < a + 2);
      2:       return s >= a;
      3:       return (s < 3) ? (f >= 134) : ((s < 5) ? 1'b0 : (f >= 100));
      default: return (s == 0) ? 1'b0 : (f >= a);
    endcase
  endfunction

  always_comb sample = samp(m_mode, m_a, m_b, slip_tot - slip_base, int'(fine));

  always @(posedge clk) if (slip) slip_tot <= slip_tot + 1;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (slip || fine != prev_fine) begin
      if (cyc - last_ev < int'(settle) + 1) viol <= viol + 1;
      last_ev <= cyc;
    end
    prev_fine <= fine;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cls(int mode, int a, int b, int s);
    bit x = samp(mode, a, b, s, INIT);
    bit y = samp(mode, a, b, s, INIT - 5);
    return (x != y) ? 2 : (x ? 1 : 0);
  endfunction

  task automatic model(input int mode, input int a, input int b,
                       output int e_err, output int e_res, output int e_slips);
    int s = 0;
    e_err = 0; e_res = 0;
    for (int p = 0; p < 2; p++) begin
      int n = 0;
      while (cls(mode, a, b, s) != p) begin
        if (n == SLIP_LIM) begin
          e_err = p + 1; e_slips = s; return;
        end
        s++; n++;
      end
    end
    for (int f = INIT; f >= 1; f--) begin
      if (!samp(mode, a, b, s, f)) begin
        e_res = f + 17; e_slips = s; return;
      end
    end
    e_err = 3; e_slips = s;
  endtask

  task automatic run(input int mode, input int a, input int b, input int st,
                     input bit restart_mid, input string tag);
    int e_err, e_res, e_slips, v0, guard;
    model(mode, a, b, e_err, e_res, e_slips);
    @(negedge clk);
    m_mode = mode; m_a = a; m_b = b; settle = 8'(st);
    slip_base = slip_tot;
    v0 = viol;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && err == 2'd0, "R2 start accepted", int'(busy), 1);
    if (restart_mid) begin
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    chk(done && !busy, {tag, " R9 done"}, int'(done), 1);
    chk(int'(err) == e_err, {tag, " err R4 R5 R7"}, int'(err), e_err);
    chk(int'(result) == e_res, {tag, " result R6 R3"}, int'(result), e_res);
    chk(slip_tot - slip_base == e_slips, {tag, " slip count R4 R5"},
        slip_tot - slip_base, e_slips);
    chk(viol == v0, {tag, " R8 settle spacing"}, viol - v0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    int r_keep, e_keep;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !slip && err == 2'd0 && result == 16'd0, "R1 reset outputs",
        int'(busy) + int'(done) + int'(slip) + int'(err) + int'(result), 0);
    chk(fine == 16'd136, "R1 reset fine", int'(fine), 136);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6 R3: periodic pulse, every slip phase, several fine skews
    for (int s0 = 0; s0 < 8; s0++) begin
      for (int bi = 0; bi < 10; bi++) begin
        int bv = (bi * 29) % 272;
        run(0, s0, bv, (s0 + bi) % 3, 1'b0, "periodic");
      end
    end

    // R2: start while busy has no effect
    run(0, 3, 40, 2, 1'b1, "restart mid-run");

    // R9: hold after done
    r_keep = int'(result); e_keep = int'(err);
    repeat (25) @(negedge clk);
    chk(done && int'(result) == r_keep && int'(err) == e_keep, "R9 hold",
        int'(result), r_keep);

    // R4 budget boundary: exactly 1024 slips, then 1025 needed
    run(1, 1024, 0, 0, 1'b0, "R4 at limit");
    run(1, 1025, 0, 0, 1'b0, "R4 over limit");
    // R5 budget boundary
    run(2, 1024, 0, 0, 1'b0, "R5 at limit");
    run(2, 1025, 0, 0, 1'b0, "R5 over limit");
    // R3 unstable readings keep slipping
    run(3, 0, 0, 1, 1'b0, "R3 unstable");
    // R6 lowest code tried, R7 code zero never tried
    run(4, 2, 0, 1, 1'b0, "R6 code one");
    run(4, 1, 0, 1, 1'b0, "R7 no edge");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule